// File: doc/BRIEF.md
# ADC Digital Trigger Qualifier

This block decides when an ADC sequencer may convert. It watches a software start command, a software stop command and one asynchronous digital trigger pin, and drives a single run-enable towards the sequencer together with a status flag that says the block is holding off for the trigger. Conversion timing, channel stepping and data handling sit elsewhere; this block only gates them.

Three behaviours are selectable. In software mode the start command enables conversion on the next clock. In hardware edge mode the block arms on start and latches the run-enable on the first matching edge of the trigger pin; from then on the pin is ignored until stop. In hardware level mode the run-enable follows the pin continuously, so the sequencer pauses while the pin is at the wrong level and resumes when it returns. The configuration is captured at the start command and held for the whole session. The pin passes through a two-flop synchronizer, which sets the latency from pin to run-enable.

Top module: `trig_qualifier`

## Requirements
- R1: With `hw_mode_i`=0 (software), a start pulse seen while idle sets `run_en_o` after that clock edge, with `wait_trig_o` low, whatever the trigger pin does.
- R2: With `hw_mode_i`=1 and `level_sel_i`=0 (edge), a start leaves the block waiting (`wait_trig_o`=1, `run_en_o`=0) until an edge chosen by `dir_i`: 0 falling, 1 rising, 2 or 3 either; the matching edge then sets `run_en_o` and clears `wait_trig_o`. An edge of the other polarity leaves it waiting.
- R3: In edge mode, pin edges whose synchronised transition finished before the start command do not fire the trigger.
- R4: Once an edge trigger has fired, later pin changes leave `run_en_o` high until stop.
- R5: In level mode with `dir_i`=0, `run_en_o` is high only while the synchronised pin is low; while it is high, `wait_trig_o` is high instead.
- R6: In level mode with `dir_i`=1, `run_en_o` is high only while the synchronised pin is high; while it is low, `wait_trig_o` is high.
- R7: In level mode with `dir_i`=2 or 3, behaviour equals software mode: `run_en_o` rises one edge after start and ignores the pin.
- R8: A pin level that is stable before rising edge n is reflected by level mode after edge n+1, and fires edge mode after edge n+2, not earlier.
- R9: A stop pulse clears `run_en_o` and `wait_trig_o` after the next edge and re-arms the block for a later start; stop wins over start in the same cycle.
- R10: Mode, type and direction are captured at start; input changes and further start pulses during an active session have no effect.
- R11: After reset both outputs are low, and `run_en_o` and `wait_trig_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start command |
| stop_i | input | 1 | One-cycle stop command |
| hw_mode_i | input | 1 | 0 software trigger, 1 hardware trigger |
| level_sel_i | input | 1 | In hardware mode: 0 edge type, 1 level type |
| dir_i | input | 2 | 0 negative, 1 positive, 2/3 either polarity |
| trig_pin_i | input | 1 | Asynchronous digital trigger pin |
| run_en_o | output | 1 | Conversion may run |
| wait_trig_o | output | 1 | Session active, holding off for the trigger |

## Verification
The assertions assume that `start_i` and `stop_i` are synchronous single-cycle pulses and that the configuration inputs matter only in the cycle of an accepted start. They also take the trigger pin as a plain level that may change at any time, with no minimum pulse width beyond what the synchronizer needs to see it. The bench drives every input on the falling clock edge, holds each pin level for at least three cycles before judging an edge, and lets the pin settle four cycles before each start so that no edge is in flight when the block arms.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

  localparam logic [1:0] DIR_NEG  = 2'd0;
  localparam logic [1:0] DIR_POS  = 2'd1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_LEVEL = 2'd3
  } qual_state_e;

  typedef struct packed {
    logic       hw;
    logic       level;
    logic [1:0] dir;
  } trig_cfg_t;

  function automatic logic level_ok(input logic [1:0] dir, input logic pin);
    case (dir)
      DIR_NEG: level_ok = ~pin;
      DIR_POS: level_ok = pin;
      default: level_ok = 1'b1;
    endcase
  endfunction

  function automatic logic edge_ok(input logic [1:0] dir, input logic rise, input logic fall);
    case (dir)
      DIR_NEG: edge_ok = fall;
      DIR_POS: edge_ok = rise;
      default: edge_ok = rise | fall;
    endcase
  endfunction

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/trig_pin_sync.sv
module trig_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pin_sync = sync_q[STAGES-1];
  assign rise     = pin_sync & ~prev_q;
  assign fall     = ~pin_sync & prev_q;
endmodule

// File: rtl/trig_qual_fsm.sv
module trig_qual_fsm
  import trig_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      stop,
  input  trig_cfg_t cfg_in,
  input  logic      pin_sync,
  input  logic      rise,
  input  logic      fall,
  output trig_cfg_t cfg_q,
  output logic      run_en,
  output logic      wait_trig
);
  qual_state_e state_q, state_d;
  logic        cfg_en;

  assign cfg_en = (state_q == ST_IDLE) && start && !stop;

  always_comb begin
    state_d = state_q;
    if (stop) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (!cfg_in.hw)                              state_d = ST_RUN;
            else if (!cfg_in.level)                      state_d = ST_ARMED;
            else if (cfg_in.dir[1])                      state_d = ST_RUN;
            else                                         state_d = ST_LEVEL;
          end
        end
        ST_ARMED: if (edge_ok(cfg_q.dir, rise, fall)) state_d = ST_RUN;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_in;
  end

  always_comb begin
    run_en    = 1'b0;
    wait_trig = 1'b0;
    case (state_q)
      ST_RUN:   run_en = 1'b1;
      ST_ARMED: wait_trig = 1'b1;
      ST_LEVEL: begin
        run_en    = level_ok(cfg_q.dir, pin_sync);
        wait_trig = ~level_ok(cfg_q.dir, pin_sync);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trig_qualifier.sv
module trig_qualifier
  import trig_qual_pkg::*;
#(
  parameter int PIN_STAGES = 2,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       hw_mode_i,
  input  logic       level_sel_i,
  input  logic [1:0] dir_i,
  input  logic       trig_pin_i,
  output logic       run_en_o,
  output logic       wait_trig_o
);
  logic      rst_sync_n;
  logic      pin_sync, pin_rise, pin_fall;
  trig_cfg_t cfg_in, cfg_q;

  assign cfg_in = '{hw: hw_mode_i, level: level_sel_i, dir: dir_i};

  trig_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  trig_pin_sync #(.STAGES(PIN_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_sync_n), .pin_async(trig_pin_i),
    .pin_sync(pin_sync), .rise(pin_rise), .fall(pin_fall)
  );

  trig_qual_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start(start_i), .stop(stop_i),
    .cfg_in(cfg_in), .pin_sync(pin_sync), .rise(pin_rise), .fall(pin_fall),
    .cfg_q(cfg_q), .run_en(run_en_o), .wait_trig(wait_trig_o)
  );
endmodule

// File: rtl/trig_qualifier_chk.sv
module trig_qualifier_chk
  import trig_qual_pkg::*;
(
  input logic      clk,
  input logic      rst_sync_n,
  input logic      start_i,
  input logic      stop_i,
  input logic      hw_mode_i,
  input logic      run_en_o,
  input logic      wait_trig_o,
  input trig_cfg_t cfg_q
);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(run_en_o && wait_trig_o));

  a_r1_sw_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start_i && !stop_i && !hw_mode_i && !run_en_o && !wait_trig_o) |=> (run_en_o && !wait_trig_o));

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_i |=> (!run_en_o && !wait_trig_o));

  a_r4_edge_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run_en_o && cfg_q.hw && !cfg_q.level && !stop_i) |=> run_en_o);

  a_r3_edge_after_arm: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(run_en_o) && cfg_q.hw && !cfg_q.level) |-> $past(wait_trig_o));

  a_r10_cfg_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((run_en_o || wait_trig_o) && !stop_i) |=> $stable(cfg_q));
endmodule

bind trig_qualifier trig_qualifier_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .start_i(start_i), .stop_i(stop_i),
  .hw_mode_i(hw_mode_i), .run_en_o(run_en_o), .wait_trig_o(wait_trig_o),
  .cfg_q(cfg_q)
);

// File: tb/tb_trig_qualifier.sv
`timescale 1ns/1ps
module tb_trig_qualifier;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, hw_mode_i = 1'b0, level_sel_i = 1'b0;
  logic [1:0] dir_i = 2'd0;
  logic trig_pin_i = 1'b0;
  logic run_en_o, wait_trig_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trig_qualifier dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .hw_mode_i(hw_mode_i), .level_sel_i(level_sel_i), .dir_i(dir_i),
    .trig_pin_i(trig_pin_i), .run_en_o(run_en_o), .wait_trig_o(wait_trig_o)
  );

  task automatic chk(input string req, input logic got_run, input logic got_wait,
                     input logic exp_run, input logic exp_wait);
    checks++;
    if (got_run !== exp_run || got_wait !== exp_wait) begin
      errors++;
      $display("FAIL %s: run/wait got %b%b expected %b%b at %0t",
               req, got_run, got_wait, exp_run, exp_wait, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; settle(1); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; settle(1); stop_i = 1'b0;
  endtask

  task automatic configure(input logic hw, input logic lvl, input logic [1:0] d);
    hw_mode_i = hw; level_sel_i = lvl; dir_i = d;
  endtask

  initial begin
    settle(2);
    rst_n = 1'b1;
    settle(5);
    chk("R11 reset", run_en_o, wait_trig_o, 1'b0, 1'b0);

    // R1 software start, pin ignored
    for (int p = 0; p < 2; p++) begin
      pulse_stop(); trig_pin_i = p[0]; settle(4);
      configure(1'b0, 1'b0, 2'd0);
      pulse_start();
      chk("R1 sw start", run_en_o, wait_trig_o, 1'b1, 1'b0);
      trig_pin_i = ~trig_pin_i; settle(4);
      chk("R1 sw pin ignored", run_en_o, wait_trig_o, 1'b1, 1'b0);
    end

    // R2/R4/R8 edge sweep: dir x initial level
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 2; p++) begin
        logic exp_fire;
        exp_fire = (d >= 2) || (d == 0 && p == 1) || (d == 1 && p == 0);
        pulse_stop(); trig_pin_i = p[0]; settle(4);
        configure(1'b1, 1'b0, d[1:0]);
        pulse_start();
        chk("R2 armed", run_en_o, wait_trig_o, 1'b0, 1'b1);
        trig_pin_i = ~p[0]; settle(2);
        chk("R8 edge not early", run_en_o, wait_trig_o, 1'b0, 1'b1);
        settle(1);
        chk("R2 edge select", run_en_o, wait_trig_o, exp_fire, ~exp_fire);
        if (!exp_fire) begin
          trig_pin_i = p[0]; settle(3);
          chk("R2 opposite edge fires", run_en_o, wait_trig_o, 1'b1, 1'b0);
        end
        for (int t = 0; t < 3; t++) begin
          trig_pin_i = ~trig_pin_i; settle(3);
          chk("R4 sticky", run_en_o, wait_trig_o, 1'b1, 1'b0);
        end
        pulse_stop();
        chk("R9 stop clears", run_en_o, wait_trig_o, 1'b0, 1'b0);
      end
    end

    // R3 edge before start ignored
    pulse_stop(); trig_pin_i = 1'b0; settle(4);
    trig_pin_i = 1'b1; settle(4);
    configure(1'b1, 1'b0, 2'd1);
    pulse_start(); settle(4);
    chk("R3 prior edge ignored", run_en_o, wait_trig_o, 1'b0, 1'b1);

    // R10 config change and second start while armed ignored
    configure(1'b1, 1'b0, 2'd0); pulse_start();
    trig_pin_i = 1'b0; settle(4);
    chk("R10 falling ignored after cfg change", run_en_o, wait_trig_o, 1'b0, 1'b1);
    configure(1'b0, 1'b0, 2'd0); settle(2);
    chk("R10 sw select ignored mid session", run_en_o, wait_trig_o, 1'b0, 1'b1);
    trig_pin_i = 1'b1; settle(3);
    chk("R10 latched rising fires", run_en_o, wait_trig_o, 1'b1, 1'b0);

    // R5/R6/R7/R8 level sweep
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 2; p++) begin
        logic e0, e1;
        string rq;
        rq = (d == 0) ? "R5" : (d == 1) ? "R6" : "R7";
        e0 = (d >= 2) ? 1'b1 : (p == d);
        e1 = (d >= 2) ? 1'b1 : ((1 - p) == d);
        pulse_stop(); trig_pin_i = p[0]; settle(4);
        configure(1'b1, 1'b1, d[1:0]);
        pulse_start();
        chk({rq, " level start"}, run_en_o, wait_trig_o, e0, ~e0);
        trig_pin_i = ~p[0]; settle(1);
        chk({rq, " R8 level not early"}, run_en_o, wait_trig_o, e0, ~e0);
        settle(1);
        chk({rq, " level follows"}, run_en_o, wait_trig_o, e1, ~e1);
        trig_pin_i = p[0]; settle(2);
        chk({rq, " level resumes"}, run_en_o, wait_trig_o, e0, ~e0);
      end
    end

    // R9 stop wins over start, then re-arm works
    pulse_stop(); configure(1'b0, 1'b0, 2'd0);
    start_i = 1'b1; stop_i = 1'b1; settle(1); start_i = 1'b0; stop_i = 1'b0;
    chk("R9 stop beats start", run_en_o, wait_trig_o, 1'b0, 1'b0);
    pulse_start();
    chk("R9 rearm", run_en_o, wait_trig_o, 1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule